// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Band and Shadowed Settings

This block produces one pulse-width-modulated channel with a high-side and a low-side output. A counter runs across a programmable period in one of two shapes. In edge mode it counts up and wraps. In symmetric mode it counts up and then back down. The counter is compared against a duty value to form a base waveform. A polarity bit can invert that waveform. The high-side output follows the base waveform and the low-side output follows its complement. Each side has its own rising-edge delay, so the two switches never conduct together, and each side has its own output inversion.

Settings arrive through a simple write port. While the channel is stopped, a write takes effect at once. While the channel runs, period, duty and delay writes land in shadow copies. All three shadow copies move into the working copies together on the clock edge where the period ends. A start request begins counting from zero on the next edge. A stop request lets the current period finish first. The `running` status output reports the channel state throughout.

Top module: `pwm_dt_channel`

## Requirements
- R1: After synchronous reset, `running`, `out_hi` and `out_lo` are 0, and every setting is 0.
- R2: `en_req` while stopped sets `running` on that clock edge and restarts the counter at 0. The outputs reflect each counter value one edge later.
- R3: `dis_req` while running keeps `running` at 1 until the edge that ends the current period, where `running` falls. An `en_req` seen before that edge cancels the pending stop.
- R4: Select codes on `wr_sel` are 0 period, 1 duty, 2 delays and 3 mode. While stopped, writes to period, duty and delays load the working values directly. While running, they load shadow values, which all become working values on the edge that ends a period.
- R5: Mode bits are: bit0 symmetric counting, bit1 polarity, bit2 dead-band enable, bit3 high-side inversion, bit4 low-side inversion. A mode write while running is ignored.
- R6: In edge mode the period lasts P cycles (counter 0..P-1). The base waveform is high while counter < D, so D=0 gives always low and D>=P gives always high.
- R7: In symmetric mode the counter goes 0..P on the way up and P-1..1 on the way down, for a period of 2P cycles. The base waveform is high for 2D contiguous cycles centred on the wrap.
- R8: With the polarity bit set, the base waveform is inverted while running.
- R9: The delay word holds the high-side delay in bits 15:0 and the low-side delay in bits 31:16. With dead-band enabled, each side rises only after its source has been high for that many cycles, and it falls at once.
- R10: With inversion bits set, each side's output is inverted. When stopped, each output rests at its inversion bit.
- R11: With both inversion bits clear, `out_hi` and `out_lo` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Start request pulse |
| dis_req | input | 1 | Stop request pulse, honoured at the end of the period |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Setting select: 0 period, 1 duty, 2 delays, 3 mode |
| wr_data | input | DW | Setting write data |
| out_hi | output | 1 | High-side output (registered) |
| out_lo | output | 1 | Low-side output (registered) |
| running | output | 1 | Channel running status |

## Verification
The assertions check the following on every cycle:
- `running` falls only on a period-ending edge.
- A start request brings the counter up at zero.
- Working period and duty hold steady between boundaries.
- The mode stays frozen while the channel runs.
- The counter never passes the period.
- The stopped outputs rest at their inversion bits.
- The two sides never overlap.

Only the bench's scenarios can show waveform content: the measured high-cycle counts per period in both counting shapes, with polarity, delays and inversion. The scenarios also show the timing of a shadowed duty change relative to the boundary, a stop request cancelled by a fresh start, and that a mode write made while running has no effect.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_DEAD   = 2'd2,
    SEL_MODE   = 2'd3
  } cfg_sel_e;

  // bit0 center, bit1 pol_low, bit2 dt_en, bit3 inv_hi, bit4 inv_lo
  typedef struct packed {
    logic inv_lo;
    logic inv_hi;
    logic dt_en;
    logic pol_low;
    logic center;
  } mode_t;

  localparam int MODE_W      = 5;
  localparam int DEAD_LO_POS = 16;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_dt_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          running,
  input  logic          wrap,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] prd,
  output logic [CW-1:0] duty,
  output logic [CW-1:0] dt_hi,
  output logic [CW-1:0] dt_lo,
  output mode_t         mode
);
  logic [CW-1:0] sh_prd, sh_duty, sh_dth, sh_dtl;
  logic [CW-1:0] f_hi, f_lo;

  assign f_hi = wr_data[CW-1:0];
  assign f_lo = wr_data[DEAD_LO_POS +: CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_prd <= '0; sh_duty <= '0; sh_dth <= '0; sh_dtl <= '0;
      prd    <= '0; duty    <= '0; dt_hi  <= '0; dt_lo  <= '0;
      mode   <= '0;
    end else begin
      if (wr_en) begin
        case (cfg_sel_e'(wr_sel))
          SEL_PERIOD: begin
            sh_prd <= f_hi;
            if (!running) prd <= f_hi;
          end
          SEL_DUTY: begin
            sh_duty <= f_hi;
            if (!running) duty <= f_hi;
          end
          SEL_DEAD: begin
            sh_dth <= f_hi;
            sh_dtl <= f_lo;
            if (!running) begin
              dt_hi <= f_hi;
              dt_lo <= f_lo;
            end
          end
          SEL_MODE: if (!running) mode <= mode_t'(wr_data[MODE_W-1:0]);
          default: ;
        endcase
      end
      if (wrap) begin
        prd   <= sh_prd;
        duty  <= sh_duty;
        dt_hi <= sh_dth;
        dt_lo <= sh_dtl;
      end
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          dis_req,
  input  logic [CW-1:0] prd,
  input  logic [CW-1:0] duty,
  input  logic          center,
  input  logic          pol_low,
  output logic          running,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          base
);
  localparam int XW = CW + 1;

  logic          up, stop_pend, stop_now, turn, hit;
  logic [XW-1:0] cnt_nx1;

  assign cnt_nx1  = {1'b0, cnt} + XW'(1);
  assign turn     = up && (cnt_nx1 >= {1'b0, prd});
  assign wrap     = running && (center ? (!up && cnt <= CW'(1)) : turn);
  assign stop_now = dis_req || (stop_pend && !en_req);
  assign hit      = up ? (cnt < duty) : (cnt <= duty);
  assign base     = running && (hit ^ pol_low);

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
      cnt       <= '0;
      up        <= 1'b1;
    end else if (!running) begin
      cnt       <= '0;
      up        <= 1'b1;
      stop_pend <= 1'b0;
      if (en_req) running <= 1'b1;
    end else if (wrap) begin
      cnt       <= '0;
      up        <= 1'b1;
      stop_pend <= 1'b0;
      running   <= !stop_now;
    end else begin
      if (dis_req)     stop_pend <= 1'b1;
      else if (en_req) stop_pend <= 1'b0;
      if (center && turn) begin
        up  <= 1'b0;
        cnt <= prd;
      end else if (up) begin
        cnt <= cnt + CW'(1);
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_dead_side.sv
module pwm_dead_side #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          src,
  input  logic          dt_en,
  input  logic          inv,
  input  logic [CW-1:0] dly,
  output logic          o
);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      o       <= 1'b0;
    end else if (!src) begin
      run_len <= '0;
      o       <= inv;
    end else if (!dt_en || run_len >= dly) begin
      o       <= !inv;
    end else begin
      run_len <= run_len + CW'(1);
      o       <= inv;
    end
  end
endmodule

// File: rtl/pwm_dt_channel.sv
module pwm_dt_channel
  import pwm_dt_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          dis_req,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          out_hi,
  output logic          out_lo,
  output logic          running
);
  localparam int NSIDE = 2;

  logic          wrap, base;
  logic [CW-1:0] cnt, prd_a, duty_a, dth_a, dtl_a;
  mode_t         mode_q;
  logic [NSIDE-1:0] side_src, side_inv, side_o;
  logic [CW-1:0]    side_dly [NSIDE];

  pwm_cfg_regs #(.CW(CW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .running(running), .wrap(wrap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .prd(prd_a), .duty(duty_a), .dt_hi(dth_a), .dt_lo(dtl_a), .mode(mode_q)
  );

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .prd(prd_a), .duty(duty_a), .center(mode_q.center), .pol_low(mode_q.pol_low),
    .running(running), .cnt(cnt), .wrap(wrap), .base(base)
  );

  assign side_src    = {running & ~base, base};
  assign side_inv    = {mode_q.inv_lo, mode_q.inv_hi};
  assign side_dly[0] = dth_a;
  assign side_dly[1] = dtl_a;

  generate
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      pwm_dead_side #(.CW(CW)) u_side (
        .clk(clk), .rst(rst), .src(side_src[s]), .dt_en(mode_q.dt_en),
        .inv(side_inv[s]), .dly(side_dly[s]), .o(side_o[s])
      );
    end
  endgenerate

  assign out_hi = side_o[0];
  assign out_lo = side_o[1];
endmodule

// File: rtl/pwm_dt_channel_chk.sv
module pwm_dt_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en_req,
  input logic          running,
  input logic          wrap,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] prd_a,
  input logic [CW-1:0] duty_a,
  input logic [4:0]    mode_q,
  input logic          out_hi,
  input logic          out_lo
);
  p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !running && en_req |=> running && cnt == '0);

  p_stop_at_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    running && !wrap |=> running);

  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (rst)
    running && !wrap |=> $stable(prd_a) && $stable(duty_a));

  p_mode_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    running && $past(running) |-> $stable(mode_q));

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    running |-> cnt <= prd_a);

  p_idle_level_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(running) |-> out_hi == $past(mode_q[3]) && out_lo == $past(mode_q[4]));

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    $past(mode_q[3] == 1'b0 && mode_q[4] == 1'b0) |-> !(out_hi && out_lo));
endmodule

bind pwm_dt_channel pwm_dt_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .en_req(en_req), .running(running), .wrap(wrap),
  .cnt(cnt), .prd_a(prd_a), .duty_a(duty_a), .mode_q(mode_q),
  .out_hi(out_hi), .out_lo(out_lo)
);

// File: tb/pwm_dt_channel_bench.sv
module pwm_dt_channel_bench;
  localparam int CW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_req = 1'b0, dis_req = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic out_hi, out_lo, running;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwm_dt_channel #(.CW(CW), .DW(DW)) u_pwm_dt_channel (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .out_hi(out_hi), .out_lo(out_lo), .running(running)
  );

  typedef struct packed {
    logic [4:0] mode;
    logic [7:0] prd;
    logic [7:0] duty;
    logic [7:0] dth;
    logic [7:0] dtl;
    logic [7:0] ehi;
    logic [7:0] elo;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{5'd0,  8'd10, 8'd3, 8'd0, 8'd0, 8'd3,  8'd7},
    '{5'd4,  8'd10, 8'd3, 8'd2, 8'd1, 8'd1,  8'd6},
    '{5'd5,  8'd8,  8'd3, 8'd1, 8'd2, 8'd5,  8'd8},
    '{5'd6,  8'd10, 8'd4, 8'd1, 8'd1, 8'd5,  8'd3},
    '{5'd0,  8'd10, 8'd0, 8'd0, 8'd0, 8'd0,  8'd10},
    '{5'd0,  8'd6,  8'd6, 8'd0, 8'd0, 8'd6,  8'd0},
    '{5'd1,  8'd5,  8'd5, 8'd0, 8'd0, 8'd10, 8'd0},
    '{5'd1,  8'd6,  8'd2, 8'd0, 8'd0, 8'd4,  8'd8},
    '{5'd12, 8'd10, 8'd3, 8'd2, 8'd1, 8'd9,  8'd6}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_en();
    en_req = 1'b1; step(1); en_req = 1'b0;
  endtask

  task automatic stop_wait();
    dis_req = 1'b1; step(1); dis_req = 1'b0;
    for (int i = 0; i < 600 && running; i++) step(1);
    step(2);
  endtask

  task automatic measure(input int len, output int nh, output int nl, output int ovl);
    nh = 0; nl = 0; ovl = 0;
    for (int i = 0; i < len; i++) begin
      step(1);
      nh += int'(out_hi);
      nl += int'(out_lo);
      if (out_hi && out_lo) ovl++;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nh, nl, ovl, len;
    step(3);
    rst = 1'b0;
    step(2);
    // R1 reset state
    chk(running == 1'b0, "R1 running after reset", int'(running), 0);
    chk(out_hi == 1'b0 && out_lo == 1'b0, "R1 outputs after reset",
        int'({out_hi, out_lo}), 0);

    // table of configurations: R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd0, DW'(VEC[v].prd));
      wr(2'd1, DW'(VEC[v].duty));
      wr(2'd2, (DW'(VEC[v].dtl) << 16) | DW'(VEC[v].dth));
      wr(2'd3, DW'(VEC[v].mode));
      len = VEC[v].mode[0] ? 2 * int'(VEC[v].prd) : int'(VEC[v].prd);
      pulse_en();
      step(3 * len + 3);
      measure(len, nh, nl, ovl);
      chk(nh == int'(VEC[v].ehi), $sformatf("R6/R7/R8/R9 case %0d high count", v),
          nh, int'(VEC[v].ehi));
      chk(nl == int'(VEC[v].elo), $sformatf("R9/R10 case %0d low count", v),
          nl, int'(VEC[v].elo));
      if (VEC[v].mode[4:3] == 2'b00)
        chk(ovl == 0, $sformatf("R11 case %0d overlap", v), ovl, 0);
      stop_wait();
    end

    // R2 start timing, R4 shadowing, R5 mode ignored while running
    wr(2'd3, '0);
    wr(2'd0, DW'(10));
    wr(2'd1, DW'(3));
    wr(2'd2, '0);
    pulse_en();                     // edge E
    chk(running == 1'b1, "R2 running right after start", int'(running), 1);
    chk(out_hi == 1'b0, "R2 output lags counter", int'(out_hi), 0);
    step(1);                        // E+1 shows cnt 0
    chk(out_hi == 1'b1, "R2 first cycle high", int'(out_hi), 1);
    step(2);                        // E+3 shows cnt 2
    chk(out_hi == 1'b1, "R6 cnt 2 high", int'(out_hi), 1);
    step(1);                        // E+4 shows cnt 3
    chk(out_hi == 1'b0, "R6 cnt 3 low", int'(out_hi), 0);
    step(6);                        // E+10
    nh = 0;
    for (int i = 0; i < 10; i++) begin   // samples E+11..E+20
      if (i == 3) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = DW'(7); end
      step(1);
      wr_en = 1'b0;
      nh += int'(out_hi);
    end
    chk(nh == 3, "R4 shadowed duty not yet used", nh, 3);
    nh = 0;
    for (int i = 0; i < 10; i++) begin   // samples E+21..E+30
      if (i == 2) begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = DW'(1); end
      step(1);
      wr_en = 1'b0;
      nh += int'(out_hi);
    end
    chk(nh == 7, "R4 shadowed duty applied at boundary", nh, 7);
    measure(10, nh, nl, ovl);            // samples E+31..E+40
    chk(nh == 7 && nl == 3, "R5 mode write while running ignored", nh, 7);

    // R3 deferred stop
    dis_req = 1'b1; step(1); dis_req = 1'b0;   // E+41
    step(8);                                   // E+49
    chk(running == 1'b1, "R3 still running before boundary", int'(running), 1);
    step(1);                                   // E+50
    chk(running == 1'b0, "R3 stopped at boundary", int'(running), 0);

    // R3 cancel by fresh start
    step(2);
    pulse_en();
    step(2);
    dis_req = 1'b1; step(1); dis_req = 1'b0;
    pulse_en();
    step(16);
    chk(running == 1'b1, "R3 stop cancelled by start", int'(running), 1);
    stop_wait();

    // R10 idle levels follow inversion bits, R5 mode write while stopped
    wr(2'd3, DW'(24));
    step(2);
    chk(out_hi == 1'b1 && out_lo == 1'b1, "R10 idle inverted levels",
        int'({out_hi, out_lo}), 3);
    wr(2'd3, DW'(8));
    step(2);
    chk(out_hi == 1'b1 && out_lo == 1'b0, "R5 R10 direct mode write while stopped",
        int'({out_hi, out_lo}), 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule